// File: doc/BRIEF.md
# Configuration Memory Stuck-Cell Classifier

This controller locates defective cells in the configuration memory of a reconfigurable logic array. It owns the serial configuration chain: it shifts a pattern in, pulses a load strobe so the cells take the chain contents, pulses a capture strobe so the chain takes the values the cells actually hold, and then shifts those values back out. Each chain position stands for one fixed physical cell, so every result is written to a defect map addressed by cell location.

After a start pulse the controller writes all cells to 1 and reads them back, then writes all cells to 0 and reads them back. From the two readback values of each cell it writes a 2-bit code to the defect map. When the verify option is set at start, it then programs a design bitstream, fetched bit by bit from an external source, and compares the readback with it. If any cell differs, it programs the bitstream a second time. Every cell that is still wrong after that second attempt is rewritten as stuck-unknown. At the end the controller raises a done flag and shows how many cells carry a non-good code.

Top module: `cfgmem_defect_classifier`

## Requirements
- R1: While reset is low, and right after it, busy, done, chain_shift, chain_load, chain_capture and map_we are all 0 and defect_count is 0.
- R2: A classification run first shifts CELLS bits of value 1 into the chain and then gives one chain_load pulse. It then shifts CELLS bits of value 0 and gives one chain_load pulse. A load pulse always directly follows a shift cycle.
- R3: Every readback begins with one chain_capture pulse, and the next cycle is the first of CELLS consecutive chain_shift cycles that sample chain_sdo.
- R4: The k-th bit shifted in a pass, counting from 0, belongs to cell k. This holds for written data, readback data, bits_addr and map_addr, and map_addr always stays below CELLS.
- R5: The code for a cell depends on its readback after the 1-pass and after the 0-pass. Read 1 then 0 gives 00 (good). Read 0 then 0 gives 01 (stuck-at-0). Read 1 then 1 gives 10 (stuck-at-1). Read 0 then 1 gives 11 (stuck-unknown).
- R6: The 0-pass readback makes exactly one map write per cell, and map writes occur only in readback shift cycles.
- R7: With verify set, the controller shifts bits_data, taken at bits_addr = k, as cell k and gives a third load pulse. If the readback matches for every cell, the run ends with no further load and no further map write.
- R8: If any cell mismatches in the first verify readback, including the last cell, the bitstream is programmed a second time. Each cell that mismatches in the second readback is written with code 11. Cells that match in the second readback are not written.
- R9: defect_count equals the number of cells whose final code is not 00. A cell is counted once even when it is rewritten, and the count never falls during a run.
- R10: busy is high from the cycle after an accepted start until the run ends. done is then high and stays high, with no strobes and no map writes, until the next start. A start pulse while busy is ignored.
- R11: At most one of chain_shift, chain_load and chain_capture is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Starts a run when idle or done |
| verify_en | input | 1 | Adds the bitstream verify pass; sampled at start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished; held until the next start |
| defect_count | output | $clog2(CELLS+1) | Number of cells with a non-good code |
| chain_sdi | output | 1 | Serial data into the configuration chain |
| chain_shift | output | 1 | Shift the chain by one position this cycle |
| chain_load | output | 1 | Cells take the chain contents |
| chain_capture | output | 1 | Chain takes the values the cells hold |
| chain_sdo | input | 1 | Serial data out of the chain (cell at the head) |
| bits_addr | output | $clog2(CELLS) | Bitstream bit being requested |
| bits_data | input | 1 | Bitstream bit at bits_addr, same cycle |
| map_we | output | 1 | Defect map write enable |
| map_addr | output | $clog2(CELLS) | Cell index of the map write |
| map_code | output | 2 | Defect code written |

## Verification
The interesting collision happens in the first verify readback. Its last cell is both the final compare and the cycle that decides whether to retry. A mismatch only on cell CELLS-1 must still cause a second bitstream programming. The bench sets up a cell that fails only on the first verify programming and sits at the last chain position. It then checks that a fourth load pulse occurs, that no cell is rewritten, and that the count stays 0. A second collision comes in the retry readback, where a cell already coded stuck-at-0 is rewritten to stuck-unknown. The bench checks that this cell's map code changes to 11 while defect_count still counts it only once.

// File: rtl/cmdc_pkg.sv
// Shared types for the configuration memory defect classifier.
// Assumes: nothing beyond IEEE 1800-2017.
package cmdc_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_LOAD,
        ST_CAPT,
        ST_READ,
        ST_DONE
    } seq_state_t;

    // Which pass the sequencer is in
    typedef enum logic [1:0] {
        PH_ONES,
        PH_ZEROS,
        PH_VFIRST,
        PH_VRETRY
    } pass_t;

    // Defect codes stored per cell
    localparam logic [1:0] CODE_GOOD = 2'b00;
    localparam logic [1:0] CODE_S0   = 2'b01;
    localparam logic [1:0] CODE_S1   = 2'b10;
    localparam logic [1:0] CODE_UNK  = 2'b11;

endpackage

// File: rtl/cmdc_seq.sv
// Sequencer: walks the passes (ones, zeros, optional verify, optional retry)
// and, within a pass, the write-shift / load / capture / read-shift steps.
// Assumes CELLS >= 2. The cell index doubles as the chain position.
module cmdc_seq
    import cmdc_pkg::*;
#(
    parameter int CELLS = 32,
    parameter int AW    = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              verify_en,
    input  logic              retry_any,
    output seq_state_t        state,
    output pass_t             phase,
    output logic [AW-1:0]     idx,
    output logic              accept
);

    localparam logic [AW-1:0] LAST = AW'(CELLS - 1);

    logic verify_q;

    // A start is taken only when no run is in progress
    assign accept = start && ((state == ST_IDLE) || (state == ST_DONE));

    // State, pass and index register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            phase    <= PH_ONES;
            idx      <= '0;
            verify_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        state    <= ST_WRITE;
                        phase    <= PH_ONES;
                        idx      <= '0;
                        verify_q <= verify_en;
                    end
                end
                ST_WRITE: begin
                    if (idx == LAST) begin
                        idx   <= '0;
                        state <= ST_LOAD;
                    end else begin
                        idx <= idx + AW'(1);
                    end
                end
                ST_LOAD: state <= ST_CAPT;
                ST_CAPT: state <= ST_READ;
                ST_READ: begin
                    if (idx == LAST) begin
                        idx <= '0;
                        case (phase)
                            PH_ONES: begin
                                phase <= PH_ZEROS;
                                state <= ST_WRITE;
                            end
                            PH_ZEROS: begin
                                if (verify_q) begin
                                    phase <= PH_VFIRST;
                                    state <= ST_WRITE;
                                end else begin
                                    state <= ST_DONE;
                                end
                            end
                            PH_VFIRST: begin
                                if (retry_any) begin
                                    phase <= PH_VRETRY;
                                    state <= ST_WRITE;
                                end else begin
                                    state <= ST_DONE;
                                end
                            end
                            default: state <= ST_DONE;
                        endcase
                    end else begin
                        idx <= idx + AW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cmdc_judge.sv
// Per-cell judgement during readback: forms the defect code, decides whether
// the map is written, flags verify mismatches and first-time defects.
// Purely combinational; assumes inputs refer to the cell at the current index.
module cmdc_judge
    import cmdc_pkg::*;
(
    input  pass_t       phase,
    input  logic        in_read,
    input  logic        first_bit,
    input  logic        read_bit,
    input  logic        want_bit,
    input  logic        already_bad,
    output logic        we,
    output logic [1:0]  code,
    output logic        vfirst_mis,
    output logic        take_first,
    output logic        newly_bad
);

    logic mismatch;

    // Code from the two classification readbacks, or unknown on retry failure
    always_comb begin
        mismatch   = read_bit ^ want_bit;
        take_first = in_read && (phase == PH_ONES);
        vfirst_mis = in_read && (phase == PH_VFIRST) && mismatch;
        if (phase == PH_VRETRY) begin
            code = CODE_UNK;
        end else begin
            code = {read_bit, ~first_bit};
        end
        we        = in_read && ((phase == PH_ZEROS) ||
                                ((phase == PH_VRETRY) && mismatch));
        newly_bad = we && (code != CODE_GOOD) && !already_bad;
    end

endmodule

// File: rtl/cmdc_store.sv
// Per-cell memory of the 1-pass readback and of the defective flag, plus the
// defect counter and the sticky first-verify mismatch flag.
// Assumes idx < CELLS whenever a take or mark is requested.
module cmdc_store #(
    parameter int CELLS = 32,
    parameter int AW    = $clog2(CELLS),
    parameter int CW    = $clog2(CELLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [AW-1:0]     idx,
    input  logic              take_first,
    input  logic              read_bit,
    input  logic              mark_bad,
    input  logic              vfirst_mis,
    output logic              first_bit,
    output logic              already_bad,
    output logic              retry_any,
    output logic [CW-1:0]     count
);

    logic [CELLS-1:0] ones_vec;
    logic [CELLS-1:0] bad_vec;
    logic             vfail_q;

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        logic one_q;
        logic bad_q;
        // Holds this cell's 1-pass readback and whether it is already coded bad
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                one_q <= 1'b0;
                bad_q <= 1'b0;
            end else if (idx == AW'(i)) begin
                if (take_first) one_q <= read_bit;
                if (mark_bad)   bad_q <= 1'b1;
            end
        end
        assign ones_vec[i] = one_q;
        assign bad_vec[i]  = bad_q;
    end

    assign first_bit   = ones_vec[idx];
    assign already_bad = bad_vec[idx];
    assign retry_any   = vfail_q | vfirst_mis;

    // Counts cells the first time they receive a non-good code
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (mark_bad) begin
            count <= count + CW'(1);
        end
    end

    // Remembers any mismatch seen earlier in the first verify readback
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vfail_q <= 1'b0;
        end else if (vfirst_mis) begin
            vfail_q <= 1'b1;
        end
    end

endmodule

// File: rtl/cfgmem_defect_classifier.sv
// Top of the configuration memory defect classifier. Drives the serial chain
// (shift/load/capture), fetches bitstream bits by index and writes 2-bit
// defect codes per cell. Assumes the chain presents the head cell on
// chain_sdo and shifts toward it, so the k-th shifted bit is cell k.
module cfgmem_defect_classifier
    import cmdc_pkg::*;
#(
    parameter int CELLS = 32,
    localparam int AW   = $clog2(CELLS),
    localparam int CW   = $clog2(CELLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              verify_en,
    output logic              busy,
    output logic              done,
    output logic [CW-1:0]     defect_count,
    output logic              chain_sdi,
    output logic              chain_shift,
    output logic              chain_load,
    output logic              chain_capture,
    input  logic              chain_sdo,
    output logic [AW-1:0]     bits_addr,
    input  logic              bits_data,
    output logic              map_we,
    output logic [AW-1:0]     map_addr,
    output logic [1:0]        map_code
);

    seq_state_t    state;
    pass_t         phase;
    logic [AW-1:0] idx;
    logic          accept;
    logic          retry_any;
    logic          first_bit;
    logic          already_bad;
    logic          vfirst_mis;
    logic          take_first;
    logic          newly_bad;
    logic          in_read;

    cmdc_seq #(.CELLS(CELLS), .AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .verify_en (verify_en),
        .retry_any (retry_any),
        .state     (state),
        .phase     (phase),
        .idx       (idx),
        .accept    (accept)
    );

    assign in_read = (state == ST_READ);

    cmdc_judge u_judge (
        .phase       (phase),
        .in_read     (in_read),
        .first_bit   (first_bit),
        .read_bit    (chain_sdo),
        .want_bit    (bits_data),
        .already_bad (already_bad),
        .we          (map_we),
        .code        (map_code),
        .vfirst_mis  (vfirst_mis),
        .take_first  (take_first),
        .newly_bad   (newly_bad)
    );

    cmdc_store #(.CELLS(CELLS), .AW(AW), .CW(CW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (accept),
        .idx         (idx),
        .take_first  (take_first),
        .read_bit    (chain_sdo),
        .mark_bad    (newly_bad),
        .vfirst_mis  (vfirst_mis),
        .first_bit   (first_bit),
        .already_bad (already_bad),
        .retry_any   (retry_any),
        .count       (defect_count)
    );

    // Chain strobes, serial data source and status decode
    always_comb begin
        chain_shift   = (state == ST_WRITE) || in_read;
        chain_load    = (state == ST_LOAD);
        chain_capture = (state == ST_CAPT);
        busy          = (state != ST_IDLE) && (state != ST_DONE);
        done          = (state == ST_DONE);
        bits_addr     = idx;
        map_addr      = idx;
        chain_sdi     = 1'b0;
        if (state == ST_WRITE) begin
            case (phase)
                PH_ONES:  chain_sdi = 1'b1;
                PH_ZEROS: chain_sdi = 1'b0;
                default:  chain_sdi = bits_data;
            endcase
        end
    end

endmodule

// File: rtl/cfgmem_defect_classifier_chk.sv
// Protocol checker for the defect classifier, attached by bind.
// Assumes it sees the top-level ports only.
module cfgmem_defect_classifier_chk #(
    parameter int CELLS = 32,
    parameter int AW    = $clog2(CELLS),
    parameter int CW    = $clog2(CELLS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] defect_count,
    input logic          chain_shift,
    input logic          chain_load,
    input logic          chain_capture,
    input logic          map_we,
    input logic [AW-1:0] map_addr
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chain_shift, chain_load, chain_capture}));          // R11

    AST_LOAD_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        chain_load |-> $past(chain_shift));                           // R2

    AST_CAPTURE_THEN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        chain_capture |=> chain_shift);                               // R3

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |-> (int'(map_addr) < CELLS));                         // R4

    AST_WRITE_ON_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |-> chain_shift);                                      // R6

    AST_COUNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (defect_count >= $past(defect_count))); // R9

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(busy || chain_shift || chain_load || chain_capture || map_we)); // R10

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);                                   // R10

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> !(busy || done || map_we));                        // R1

endmodule

bind cfgmem_defect_classifier cfgmem_defect_classifier_chk #(
    .CELLS(CELLS), .AW(AW), .CW(CW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .defect_count  (defect_count),
    .chain_shift   (chain_shift),
    .chain_load    (chain_load),
    .chain_capture (chain_capture),
    .map_we        (map_we),
    .map_addr      (map_addr)
);

// File: tb/cfgmem_defect_classifier_test.sv
// Bench: models the configuration chain with injectable faults, walks a table
// of fault scenarios, then runs directed reset and corner-case tests.
module cfgmem_defect_classifier_test;

    localparam int N      = 32;
    localparam int AW     = $clog2(N);
    localparam int CW     = $clog2(N + 1);
    localparam int CLK_NS = 10;
    localparam int NVEC   = 6;

    // Scenario table: stuck-0, stuck-1, inverting, first-verify-only, persistent
    localparam logic [N-1:0] T_S0 [0:NVEC-1] = '{32'h0, 32'h0000_0001, 32'h0, 32'h0000_0100, 32'h0000_0004, 32'h0};
    localparam logic [N-1:0] T_S1 [0:NVEC-1] = '{32'h0, 32'h8000_0000, 32'h0, 32'h0, 32'h0000_0010, 32'h0};
    localparam logic [N-1:0] T_FL [0:NVEC-1] = '{32'h0, 32'h0001_0000, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam logic [N-1:0] T_FK [0:NVEC-1] = '{32'h0, 32'h0, 32'h0, 32'h0000_0002, 32'h0, 32'h8000_0000};
    localparam logic [N-1:0] T_PS [0:NVEC-1] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h8000_0040, 32'h0};
    localparam logic         T_VE [0:NVEC-1] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic [N-1:0] VBITS = 32'hA5A5_3C3C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          verify_en = 1'b0;
    logic          busy, done;
    logic [CW-1:0] defect_count;
    logic          chain_sdi, chain_shift, chain_load, chain_capture, chain_sdo;
    logic [AW-1:0] bits_addr;
    logic          bits_data;
    logic          map_we;
    logic [AW-1:0] map_addr;
    logic [1:0]    map_code;

    int total = 0;
    int bad = 0;

    logic [N-1:0] s0m = '0, s1m = '0, flm = '0, fkm = '0, psm = '0;
    logic [N-1:0] chain_q = '0, prog_q = '0;
    logic [N-1:0] loaded [0:7];
    int lc = 0;
    int base_lc = 0;
    int clr_gen = 0, seen_gen = 0;
    logic [2*N-1:0] mapv = '0;
    int wcnt = 0;
    int v_excl = 0, v_capt = 0;
    logic prev_capt = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    cfgmem_defect_classifier #(.CELLS(N)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .verify_en(verify_en),
        .busy(busy), .done(done), .defect_count(defect_count),
        .chain_sdi(chain_sdi), .chain_shift(chain_shift), .chain_load(chain_load),
        .chain_capture(chain_capture), .chain_sdo(chain_sdo),
        .bits_addr(bits_addr), .bits_data(bits_data),
        .map_we(map_we), .map_addr(map_addr), .map_code(map_code)
    );

    assign chain_sdo = chain_q[0];
    assign bits_data = VBITS[bits_addr];

    // Cell values seen by a capture after the k-th load of a run
    function automatic logic [N-1:0] rd(input logic [N-1:0] p, input int k);
        logic [N-1:0] r;
        r = ((p ^ flm) & ~s0m) | s1m;
        if (k == 3) r = r ^ (fkm | psm);
        if (k == 4) r = r ^ psm;
        return r;
    endfunction

    // Chain and cell model
    always @(posedge clk) begin
        if (chain_shift) chain_q <= {chain_sdi, chain_q[N-1:1]};
        if (chain_load) begin
            prog_q <= chain_q;
            loaded[(lc + 1 - base_lc) & 7] <= chain_q;
            lc <= lc + 1;
        end
        if (chain_capture) chain_q <= rd(prog_q, lc - base_lc);
    end

    // Map recorder and strobe monitors, away from the active edge
    always @(negedge clk) begin
        if (clr_gen != seen_gen) begin
            seen_gen <= clr_gen;
            mapv     <= '0;
            wcnt     <= 0;
        end else if (rst_n && map_we) begin
            mapv[2*int'(map_addr) +: 2] <= map_code;
            wcnt <= wcnt + 1;
        end
        if (rst_n && (int'(chain_shift) + int'(chain_load) + int'(chain_capture) > 1)) v_excl <= v_excl + 1;
        if (rst_n && prev_capt && !chain_shift) v_capt <= v_capt + 1;
        prev_capt <= chain_capture;
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Start a run and wait for done; optional extra start pulse while busy
    task automatic run(input int vi, input int extra_at);
        int cyc;
        s0m = T_S0[vi]; s1m = T_S1[vi]; flm = T_FL[vi]; fkm = T_FK[vi]; psm = T_PS[vi];
        verify_en = T_VE[vi];
        clr_gen++;
        @(negedge clk);
        base_lc = lc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        verify_en = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (cyc == extra_at) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        chk(cyc < 2000, "R10 run finished", 64'(cyc), 64'd2000);
    endtask

    // Compare the run outcome against expectations derived from the requirements
    task automatic judge(input int vi);
        logic [N-1:0] r1, r0, ra, rb, fails;
        logic [2*N-1:0] em;
        int ecnt, ewr, eld;
        logic retry;
        r1 = rd('1, 1);
        r0 = rd('0, 2);
        em = '0;
        for (int i = 0; i < N; i++) em[2*i +: 2] = {r0[i], ~r1[i]};   // R5 code table
        ewr = N;
        eld = 2;
        if (T_VE[vi]) begin
            eld = 3;
            ra = rd(VBITS, 3);
            retry = |(ra ^ VBITS);
            if (retry) begin
                eld = 4;
                rb = rd(VBITS, 4);
                fails = rb ^ VBITS;
                for (int i = 0; i < N; i++) begin
                    if (fails[i]) begin
                        em[2*i +: 2] = 2'b11;
                        ewr++;
                    end
                end
            end
        end
        ecnt = 0;
        for (int i = 0; i < N; i++) if (em[2*i +: 2] != 2'b00) ecnt++;
        chk(mapv == em, "R5/R8 defect map codes", mapv, em);
        chk(int'(defect_count) == ecnt, "R9 defect count", 64'(defect_count), 64'(ecnt));
        chk(wcnt == ewr, "R6/R8 map write count", 64'(wcnt), 64'(ewr));
        chk((lc - base_lc) == eld, "R7/R8 load pulses", 64'(lc - base_lc), 64'(eld));
        chk(loaded[1] == '1 && loaded[2] == '0, "R2 uniform patterns", {loaded[1], loaded[2]}, {{N{1'b1}}, {N{1'b0}}});
        if (T_VE[vi]) chk(loaded[3] == VBITS, "R4 bitstream order", 64'(loaded[3]), 64'(VBITS));
        chk(done && !busy, "R10 done and not busy", {62'd0, done, busy}, 64'd2);
    endtask

    // Global watchdog
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R10 watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !chain_shift && !chain_load && !chain_capture && !map_we,
            "R1 outputs in reset", {busy, done, chain_shift, chain_load, chain_capture, map_we}, 64'd0);
        chk(defect_count == '0, "R1 count in reset", 64'(defect_count), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !map_we, "R1 idle after reset", {busy, done, map_we}, 64'd0);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            run(v, 0);
            judge(v);
        end

        // R10: start during a run is ignored
        run(1, 40);
        judge(1);

        // R10: done held, nothing written while parked
        begin
            int w0;
            w0 = wcnt;
            repeat (6) @(negedge clk);
            chk(done && !busy && wcnt == w0, "R10 done held quietly",
                {busy, done, 62'(wcnt)}, {1'b0, 1'b1, 62'(w0)});
        end

        chk(v_capt == 0, "R3 capture followed by shift", 64'(v_capt), 64'd0);
        chk(v_excl == 0, "R11 strobes exclusive", 64'(v_excl), 64'd0);

        // R1: reset in mid-run returns to idle
        clr_gen++;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!busy && !done && defect_count == '0 && !chain_shift, "R1 reset mid-run",
            {busy, done, 62'(defect_count)}, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule